// File: doc/BRIEF.md
# Time-Based Port Arbitration Scheduler

This block chooses, cycle by cycle, which of several ingress ports may send its next packet into one virtual channel. Three policies are available. Plain round robin gives each requester a turn in circular order. Table-driven weighted round robin walks a programmable phase table in which each entry names the port that owns that phase. Time-based weighted round robin spends one reference-clock period on each table slot. In that mode a port can only be served inside its own slots, so its bandwidth is capped at the share of slots it holds.

The table is written through a staging copy. A load request moves the staged contents into the active schedule, but only at a phase boundary. In timed mode that boundary is the next reference tick. In the other modes every cycle is a boundary. A pending flag tells software whether the active schedule still differs from what it wrote. The policy is picked by a 3-bit select. Codes that the build's capability mask does not list are ignored.

Top module: `port_arb_sched`

## Requirements
- R1: After reset, no grant is asserted, `tbl_pending` is 0 and `active_mode` is 0 (round robin). Every active table entry is 0 and the round-robin pointer sits at the last port, so port 0 is the first one served.
- R2: `gnt` has at most one bit set. A bit is set only for a port whose `req` bit was high at the clock edge that registered the grant, and it appears the cycle after that edge.
- R3: Mode 0 (round robin) grants the first requesting port found by scanning circularly from the port after the one granted last. If no port requests, there is no grant.
- R4: Mode 1 (table-driven weighted) scans the active table circularly from the phase pointer. Phases whose owner is not requesting are skipped within the same cycle. The first phase whose owner requests is granted, and the pointer moves to the phase after it. If no owner requests, there is no grant and the pointer stays where it is.
- R5: Each table entry is 2^SIZE_CODE bits wide and holds a port number. An entry whose value is NUM_PORTS or more owns no port and is never granted.
- R6: Mode 2 (timed) serves only the owner of the current slot, and serves it at most once per slot. A slot whose owner is idle passes unused, and no other port is served in it.
- R7: In mode 2 the slot index moves forward by one on each `ref_tick` and wraps from MAX_SLOTS-1 back to 0. Ticks have no effect in the other modes.
- R8: `mode_sel` codes are 0 = round robin, 1 = table weighted, 2 = timed. A code is taken one cycle after it is presented, and only if its bit is set in CAP_MASK and it is one of these three. Any other code leaves `active_mode` unchanged. Taking a new mode restarts the phase pointer and the slot at 0.
- R9: A table write sets `tbl_pending`. A completed load clears it, unless a write arrives in the same cycle as the load, in which case it stays set.
- R10: Written entries have no effect on scheduling until a load commits them. A load commits in its own cycle in modes 0 and 1. In mode 2 it is held until the next `ref_tick`. A commit restarts the phase pointer and the slot at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_PORTS | Per-port request lines |
| mode_sel | input | 3 | Requested arbitration scheme |
| ref_tick | input | 1 | One-cycle pulse marking each reference period |
| tbl_we | input | 1 | Staged table write strobe |
| tbl_addr | input | log2(PHASES) | Staged table entry index |
| tbl_wdata | input | 2^SIZE_CODE | Port number written into the entry |
| tbl_load | input | 1 | Request to commit the staged table |
| gnt | output | NUM_PORTS | Registered one-hot grant |
| tbl_pending | output | 1 | Active table differs from written contents |
| active_mode | output | 3 | Scheme currently in force |

## Verification
Two functions can meet on one clock edge: a table write, and the commit of an earlier load at a timed-mode reference tick. The bench provokes this by holding a load in timed mode across cycles with no tick, then writing a new entry in exactly the tick cycle. It judges the result in two ways. First, the pending flag must stay set, because the write came in the same cycle as the load. Second, the grants that follow must match the table as it was staged before that write. A second collision, a mode change landing in the same cycle as a grant decision, is checked in the same way against a cycle-accurate model kept in the bench.

// File: rtl/port_arb_pkg.sv
package port_arb_pkg;

  typedef enum logic [2:0] {
    ARB_RR    = 3'd0,
    ARB_WRR   = 3'd1,
    ARB_TIMED = 3'd2
  } arb_mode_e;

  // Schemes this implementation actually provides.
  localparam logic [7:0] ARB_IMPLEMENTED = 8'b0000_0111;

endpackage

// File: rtl/port_arb_table.sv
// Staged and active copies of the phase table with the load handshake.
module port_arb_table #(
  parameter int PHASES = 8,
  parameter int ENT_W  = 4,
  localparam int AW    = $clog2(PHASES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [AW-1:0]                  addr,
  input  logic [ENT_W-1:0]               wdata,
  input  logic                           load,
  input  logic                           boundary,
  output logic [PHASES-1:0][ENT_W-1:0]   act_tbl,
  output logic                           commit,
  output logic                           pending
);

  logic [PHASES-1:0][ENT_W-1:0] staged_q, staged_d;
  logic [PHASES-1:0][ENT_W-1:0] active_q, active_d;
  logic                         lpend_q, lpend_d;
  logic                         dirty_q, dirty_d;
  logic                         load_req;

  always_comb begin
    staged_d = staged_q;
    if (we) staged_d[addr] = wdata;
    load_req = lpend_q | load;
    commit   = load_req & boundary;
    lpend_d  = load_req & ~boundary;
    active_d = commit ? staged_q : active_q;
    if (we)          dirty_d = 1'b1;
    else if (commit) dirty_d = 1'b0;
    else             dirty_d = dirty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= '0;
      active_q <= '0;
      lpend_q  <= 1'b0;
      dirty_q  <= 1'b0;
    end else begin
      staged_q <= staged_d;
      active_q <= active_d;
      lpend_q  <= lpend_d;
      dirty_q  <= dirty_d;
    end
  end

  assign act_tbl = active_q;
  assign pending = dirty_q;

endmodule

// File: rtl/port_arb_rr.sv
// Circular round-robin selection among requesting ports.
module port_arb_rr #(
  parameter int NP  = 4,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NP-1:0] req,
  output logic [NP-1:0] gnt
);

  logic [PW-1:0] last_q, last_d;
  logic [PW-1:0] pick;
  logic          found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    pick  = last_q;
    for (int k = 1; k <= NP; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NP;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        pick     = PW'(idx);
      end
    end
    last_d = (en && found) ? pick : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= PW'(NP - 1);
    else        last_q <= last_d;
  end

endmodule

// File: rtl/port_arb_walk.sv
// Phase walker for table-driven and time-based weighted schemes.
module port_arb_walk #(
  parameter int         NP        = 4,
  parameter int         PHASES    = 8,
  parameter int         ENT_W     = 4,
  parameter logic [6:0] MAX_SLOTS = 7'd6,
  localparam int        SW        = $clog2(PHASES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wrr_en,
  input  logic                          timed_en,
  input  logic                          tick,
  input  logic                          restart,
  input  logic [NP-1:0]                 req,
  input  logic [PHASES-1:0][ENT_W-1:0]  act_tbl,
  output logic [NP-1:0]                 wrr_gnt,
  output logic [NP-1:0]                 timed_gnt
);

  logic [PHASES-1:0][NP-1:0] owner;
  logic [SW-1:0]             ph_q, ph_d, ph_hit;
  logic [SW-1:0]             slot_q, slot_d, slot_inc;
  logic                      used_q, used_d;
  logic                      w_found;

  // Decode each entry into a one-hot owner; out-of-range values own nothing.
  for (genvar p = 0; p < PHASES; p++) begin : g_own
    always_comb begin
      for (int q = 0; q < NP; q++) owner[p][q] = (int'(act_tbl[p]) == q);
    end
  end

  always_comb begin
    wrr_gnt = '0;
    w_found = 1'b0;
    ph_hit  = ph_q;
    for (int k = 0; k < PHASES; k++) begin
      int idx;
      idx = (int'(ph_q) + k) % PHASES;
      if (!w_found && |(owner[idx] & req)) begin
        w_found = 1'b1;
        wrr_gnt = owner[idx] & req;
        ph_hit  = SW'((idx + 1) % PHASES);
      end
    end
  end

  always_comb begin
    timed_gnt = used_q ? '0 : (owner[slot_q] & req);
    slot_inc  = (int'(slot_q) == int'(MAX_SLOTS) - 1) ? '0 : slot_q + 1'b1;
  end

  always_comb begin
    ph_d   = ph_q;
    slot_d = slot_q;
    used_d = used_q;
    if (restart) begin
      ph_d   = '0;
      slot_d = '0;
      used_d = 1'b0;
    end else begin
      if (wrr_en && w_found) ph_d = ph_hit;
      if (timed_en) begin
        if (tick) begin
          slot_d = slot_inc;
          used_d = 1'b0;
        end else if (|timed_gnt) begin
          used_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      slot_q <= '0;
      used_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      slot_q <= slot_d;
      used_q <= used_d;
    end
  end

endmodule

// File: rtl/port_arb_sched.sv
module port_arb_sched #(
  parameter int         NUM_PORTS = 4,
  parameter int         PHASES    = 8,
  parameter int         SIZE_CODE = 2,
  parameter logic [6:0] MAX_SLOTS = 7'd6,
  parameter logic [7:0] CAP_MASK  = 8'b0000_0111,
  localparam int        ENT_W     = 1 << SIZE_CODE,
  localparam int        AW        = $clog2(PHASES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req,
  input  logic [2:0]           mode_sel,
  input  logic                 ref_tick,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic [ENT_W-1:0]     tbl_wdata,
  input  logic                 tbl_load,
  output logic [NUM_PORTS-1:0] gnt,
  output logic                 tbl_pending,
  output logic [2:0]           active_mode
);
  import port_arb_pkg::*;

  localparam logic [7:0] CAP_EFF = CAP_MASK & ARB_IMPLEMENTED;

  arb_mode_e                     mode_q, mode_d;
  logic                          mode_chg, boundary, commit, restart;
  logic [PHASES-1:0][ENT_W-1:0]  act_tbl;
  logic [NUM_PORTS-1:0]          rr_gnt, wrr_gnt, timed_gnt;
  logic [NUM_PORTS-1:0]          gnt_q, gnt_d;

  always_comb begin
    mode_chg = CAP_EFF[mode_sel] && (mode_sel != mode_q);
    mode_d   = mode_chg ? arb_mode_e'(mode_sel) : mode_q;
    boundary = (mode_q != ARB_TIMED) || ref_tick;
    restart  = commit || mode_chg;
  end

  port_arb_table #(.PHASES(PHASES), .ENT_W(ENT_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (tbl_we),
    .addr     (tbl_addr),
    .wdata    (tbl_wdata),
    .load     (tbl_load),
    .boundary (boundary),
    .act_tbl  (act_tbl),
    .commit   (commit),
    .pending  (tbl_pending)
  );

  port_arb_rr #(.NP(NUM_PORTS)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mode_q == ARB_RR),
    .req   (req),
    .gnt   (rr_gnt)
  );

  port_arb_walk #(
    .NP(NUM_PORTS), .PHASES(PHASES), .ENT_W(ENT_W), .MAX_SLOTS(MAX_SLOTS)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrr_en    (mode_q == ARB_WRR),
    .timed_en  (mode_q == ARB_TIMED),
    .tick      (ref_tick),
    .restart   (restart),
    .req       (req),
    .act_tbl   (act_tbl),
    .wrr_gnt   (wrr_gnt),
    .timed_gnt (timed_gnt)
  );

  always_comb begin
    unique case (mode_q)
      ARB_RR:    gnt_d = rr_gnt;
      ARB_WRR:   gnt_d = wrr_gnt;
      ARB_TIMED: gnt_d = timed_gnt;
      default:   gnt_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ARB_RR;
      gnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      gnt_q  <= gnt_d;
    end
  end

  assign gnt         = gnt_q;
  assign active_mode = mode_q;

endmodule

// File: rtl/port_arb_sched_chk.sv
module port_arb_sched_chk #(
  parameter int         NUM_PORTS = 4,
  parameter int         PHASES    = 8,
  parameter int         SIZE_CODE = 2,
  parameter logic [7:0] CAP_MASK  = 8'b0000_0111,
  localparam int        ENT_W     = 1 << SIZE_CODE,
  localparam int        AW        = $clog2(PHASES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] req,
  input logic [2:0]           mode_sel,
  input logic                 ref_tick,
  input logic                 tbl_we,
  input logic [AW-1:0]        tbl_addr,
  input logic [ENT_W-1:0]     tbl_wdata,
  input logic                 tbl_load,
  input logic [NUM_PORTS-1:0] gnt,
  input logic                 tbl_pending,
  input logic [2:0]           active_mode
);

  localparam logic [7:0] LEGAL = CAP_MASK & 8'b0000_0111;

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r2_granted_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~$past(req)) == '0);

  a_r8_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !LEGAL[mode_sel] |=> $stable(active_mode));

  a_r9_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> tbl_pending);

  a_r10_timed_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 3'd2 && !ref_tick && !tbl_we && tbl_pending) |=> tbl_pending);

endmodule

bind port_arb_sched port_arb_sched_chk #(
  .NUM_PORTS(NUM_PORTS), .PHASES(PHASES), .SIZE_CODE(SIZE_CODE), .CAP_MASK(CAP_MASK)
) u_chk (.*);

// File: tb/test_port_arb_sched.sv
module test_port_arb_sched;

  localparam int NP = 4;
  localparam int PH = 8;
  localparam int MS = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] req;
  logic [2:0]    mode_sel;
  logic          ref_tick;
  logic          tbl_we;
  logic [2:0]    tbl_addr;
  logic [3:0]    tbl_wdata;
  logic          tbl_load;
  logic [NP-1:0] gnt;
  logic          tbl_pending;
  logic [2:0]    active_mode;

  int errors = 0;
  int checks = 0;

  // Bench model state
  int m_mode, m_last, m_ph, m_slot;
  bit m_used, m_pend, m_lpend;
  int m_act[PH];
  int m_stg[PH];

  always #5 clk = ~clk;

  port_arb_sched #(
    .NUM_PORTS(NP), .PHASES(PH), .SIZE_CODE(2), .MAX_SLOTS(7'd6), .CAP_MASK(8'b0000_0111)
  ) i_port_arb_sched (
    .clk(clk), .rst_n(rst_n), .req(req), .mode_sel(mode_sel), .ref_tick(ref_tick),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_load(tbl_load),
    .gnt(gnt), .tbl_pending(tbl_pending), .active_mode(active_mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int r, input bit tk, input int ms, input bit we,
                      input int a, input int d, input bit ld, input string tag);
    int  g;
    bit  boundary, lreq, commit;
    int  n_last, n_ph, n_slot;
    bit  n_used;
    req = NP'(r); ref_tick = tk; mode_sel = 3'(ms);
    tbl_we = we; tbl_addr = 3'(a); tbl_wdata = 4'(d); tbl_load = ld;
    g = 0; n_last = m_last; n_ph = m_ph; n_slot = m_slot; n_used = m_used;
    if (m_mode == 0) begin
      for (int k = 1; k <= NP; k++) begin
        int idx = (m_last + k) % NP;
        if (g == 0 && r[idx]) begin g = 1 << idx; n_last = idx; end
      end
    end else if (m_mode == 1) begin
      for (int k = 0; k < PH; k++) begin
        int idx = (m_ph + k) % PH;
        if (g == 0 && m_act[idx] < NP && r[m_act[idx]]) begin
          g = 1 << m_act[idx]; n_ph = (idx + 1) % PH;
        end
      end
    end else begin
      if (!m_used && m_act[m_slot] < NP && r[m_act[m_slot]]) g = 1 << m_act[m_slot];
      if (tk) begin n_slot = (m_slot == MS - 1) ? 0 : m_slot + 1; n_used = 0; end
      else if (g != 0) n_used = 1;
    end
    boundary = (m_mode != 2) || tk;
    lreq = m_lpend || ld;
    commit = lreq && boundary;
    m_lpend = lreq && !boundary;
    if (commit) begin
      for (int i = 0; i < PH; i++) m_act[i] = m_stg[i];
      n_ph = 0; n_slot = 0; n_used = 0;
    end
    if (we) begin m_stg[a] = d; m_pend = 1; end
    else if (commit) m_pend = 0;
    if (ms <= 2 && ms != m_mode) begin
      m_mode = ms; n_ph = 0; n_slot = 0; n_used = 0;
    end
    m_last = n_last; m_ph = n_ph; m_slot = n_slot; m_used = n_used;
    @(posedge clk); #1;
    check({tag, " gnt"}, int'(gnt), g);
    check({tag, " pending"}, int'(tbl_pending), int'(m_pend));
    check({tag, " mode"}, int'(active_mode), m_mode);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int cur_mode;
    rst_n = 1'b0; req = '0; mode_sel = '0; ref_tick = 0;
    tbl_we = 0; tbl_addr = '0; tbl_wdata = '0; tbl_load = 0;
    m_mode = 0; m_last = NP - 1; m_ph = 0; m_slot = 0;
    m_used = 0; m_pend = 0; m_lpend = 0;
    for (int i = 0; i < PH; i++) begin m_act[i] = 0; m_stg[i] = 0; end
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 gnt", int'(gnt), 0);
    check("R1 pending", int'(tbl_pending), 0);
    check("R1 mode", int'(active_mode), 0);
    rst_n = 1'b1;

    // R2 R3: round robin over every request pattern
    for (int c = 0; c < 48; c++) step(((c * 5) + (c >> 4)) & 15, c[0], 0, 0, 0, 0, 0, "R2 R3 rr");

    // R8: unsupported selects are ignored
    for (int v = 3; v < 8; v++) step(15, 0, v, 0, 0, 0, 0, "R8 illegal");

    // R9: writes set pending; R10: no effect before load
    begin
      int ent[PH] = '{0, 1, 1, 2, 7, 3, 2, 5};
      for (int i = 0; i < PH; i++) step(15, 0, 0, 1, i, ent[i], 0, "R9 write");
    end
    step(6, 0, 0, 0, 0, 0, 1, "R10 load rr");

    // R4 R5: table-driven weighted sweep (entries 7 and 5 own nothing)
    for (int c = 0; c < 64; c++) step(((c * 3) ^ (c >> 2)) & 15, 0, 1, 0, 0, 0, 0, "R4 R5 wrr");

    // R6 R7: timed slots with ticks every third cycle
    for (int c = 0; c < 72; c++)
      step((c % 5 == 0) ? 15 : ((c * 7 + 1) & 15), (c % 3) == 2, 2, 0, 0, 0, 0, "R6 R7 timed");

    // R10: timed load waits for tick; R9: write in the commit cycle keeps pending
    step(15, 0, 2, 1, 0, 3, 0, "R9 timed write");
    step(15, 0, 2, 0, 0, 0, 1, "R10 held load");
    for (int c = 0; c < 4; c++) step(15, 0, 2, 0, 0, 0, 0, "R10 held load");
    step(15, 1, 2, 1, 1, 0, 0, "R9 write at commit");
    for (int c = 0; c < 12; c++) step(15, (c % 2) == 1, 2, 0, 0, 0, 0, "R6 R10 after commit");
    step(15, 0, 2, 0, 0, 0, 1, "R10 second load");
    step(15, 1, 2, 0, 0, 0, 0, "R10 commit at tick");

    // R8: legal switch back with a pattern, then illegal attempt
    for (int c = 0; c < 16; c++) begin
      cur_mode = (c < 8) ? 1 : ((c == 8) ? 6 : 0);
      step(c & 15, c[1], cur_mode, 0, 0, 0, 0, "R4 R8 switch");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule